// File: doc/BRIEF.md
# Half-Duplex MII Transmit Collision Handler

This block is the transmit half of a half-duplex Ethernet MAC on a 4-bit media-independent interface. A frame source offers one nibble at a time. The block streams the nibbles onto `txd_o` with `tx_en_o` high, one per transmit clock. It watches the PHY's carrier-sense and collision lines, and each of them passes through a two-flop synchronizer first.

When a collision is seen mid-frame, the rest of the frame is dropped and a fixed jam pattern of eight 0x5 nibbles goes out instead. The block then waits a pseudo-random number of slot times. The window for that wait doubles with each collision until it reaches a cap. After the wait the frame is replayed from its first nibble. The frame source must be able to rewind, and the block asks for this with a one-cycle rewind strobe.

The block reports each frame as sent or aborted with a one-cycle pulse. A frame is aborted when its last permitted attempt also collides. In full-duplex mode carrier sense and collision are ignored, and only the inter-frame gap governs when a frame starts.

Top module: `hdx_mii_tx`

## Requirements
- R1: While `rst_n` is low and in the first clock after it rises, `tx_en_o`, `txd_o`, `sent_ok_o`, `sent_abort_o`, `src_next_o` and `src_rewind_o` are all 0.
- R2: A frame without a collision appears as one unbroken burst with `tx_en_o` high, carrying the source nibbles in order from nibble 0 to the nibble flagged by `src_last_i`. `sent_ok_o` is high for exactly one clock, which is the first clock with `tx_en_o` low after the burst.
- R3: In half-duplex mode (`half_duplex_i`=1), a synchronized collision during a frame ends the data. Exactly JAM_NIBBLES (8) nibbles of value 0x5 follow on `txd_o`. `tx_en_o` stays high through the jam and drops on the clock after the last jam nibble.
- R4: Every retry starts again at nibble 0 of the frame. The rewind request `src_rewind_o` is high for one clock at the end of each jam.
- R5: After the n-th collision of a frame, `tx_en_o` stays low for at most max(IFG_NIBBLES+2, (2^min(n,BACKOFF_CAP)−1)·SLOT_CLKS+3) clocks before the retry burst. The slot count is drawn from an internal LFSR.
- R6: A frame gets at most MAX_ATTEMPTS (16) attempts. When the last of them collides, `sent_abort_o` pulses for one clock as its jam ends, and `sent_ok_o` does not pulse for that frame.
- R7: With `half_duplex_i`=0, `col_i` and `crs_i` have no effect: the frame goes out whole and completes with no jam.
- R8: In half-duplex mode no burst starts while synchronized carrier sense is high. After `crs_i` falls, at least IFG_NIBBLES+2 clocks pass before `tx_en_o` rises.
- R9: Between any two bursts `tx_en_o` is low for at least IFG_NIBBLES+2 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit nibble clock |
| rst_n | input | 1 | Synchronous active-low reset |
| half_duplex_i | input | 1 | 1 selects half-duplex (collision and carrier sense active) |
| frame_pending_i | input | 1 | Source holds a frame; kept high until a completion pulse |
| src_nibble_i | input | 4 | Current frame nibble from the source |
| src_last_i | input | 1 | Current nibble is the final one of the frame |
| src_next_o | output | 1 | Source advances to the next nibble at this edge |
| src_rewind_o | output | 1 | Source returns to nibble 0 at this edge |
| crs_i | input | 1 | PHY carrier sense, asynchronous |
| col_i | input | 1 | PHY collision indication, asynchronous |
| txd_o | output | 4 | Transmit nibble to the PHY |
| tx_en_o | output | 1 | Transmit enable to the PHY |
| sent_ok_o | output | 1 | One-clock pulse: frame transmitted |
| sent_abort_o | output | 1 | One-clock pulse: frame dropped after too many collisions |

## Verification
The hardest case to reach from the ports is a frame that collides on every one of its sixteen attempts. Each retry comes after a random backoff that the bench cannot predict. The bench handles this with a collision injector that pulses `col_i` a fixed number of clocks into every burst, up to a per-test quota. A quota of 3 gives the collide-then-succeed case, and a large quota forces the abort. Because the delays are random, the bench checks each retry gap against the requirement's bounds instead of an exact cycle. It also checks every burst to be a clean prefix of the frame followed by exactly eight jam nibbles.

// File: rtl/hdx_tx_pkg.sv
// Package: shared state encoding and constants for the half-duplex
// MII transmit collision handler.
package hdx_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_TX      = 3'd1,
        ST_DONE    = 3'd2,
        ST_JAM     = 3'd3,
        ST_BACKOFF = 3'd4
    } tx_state_e;

    localparam logic [3:0] JAM_NIBBLE = 4'h5;

endpackage

// File: rtl/hdx_sync2.sv
// Module: hdx_sync2
// Two-stage synchronizer for asynchronous level inputs.
// Assumes: each input bit is an independent level, so per-bit
// resolution is acceptable (no multi-bit coherence is required).
module hdx_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] meta;

    // Capture the asynchronous inputs, then retime them once more.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q_o  <= '0;
        end else begin
            meta <= d_i;
            q_o  <= meta;
        end
    end

endmodule

// File: rtl/hdx_lfsr.sv
// Module: hdx_lfsr
// Free-running Galois LFSR that supplies backoff randomness.
// Assumes: TAPS gives a maximal-length polynomial for W and SEED is
// nonzero. Only the low OUT_W bits are exported.
module hdx_lfsr #(
    parameter int             W     = 16,
    parameter int             OUT_W = 10,
    parameter logic [W-1:0]   TAPS  = W'(16'hB400),
    parameter logic [W-1:0]   SEED  = W'(16'hACE1)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [OUT_W-1:0] rnd_o
);

    logic [W-1:0] st;

    // Advance the register by one step every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= SEED;
        end else begin
            st <= {1'b0, st[W-1:1]} ^ (st[0] ? TAPS : '0);
        end
    end

    assign rnd_o = st[OUT_W-1:0];

    assert_lfsr_alive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st != '0);

endmodule

// File: rtl/hdx_backoff.sv
// Module: hdx_backoff
// Backoff timer that counts whole slots of SLOT_CLKS clocks.
// Assumes: load_i pulses once per collision. zero_o is high whenever
// no slots remain, including the clock after a load of zero.
module hdx_backoff #(
    parameter int SLOT_CLKS = 128,
    parameter int CAP       = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load_i,
    input  logic [CAP-1:0] slots_i,
    output logic           zero_o
);

    localparam int SUB_W = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1;

    logic [CAP-1:0]   slots;
    logic [SUB_W-1:0] sub;

    // Load a slot count, then count it down one slot time at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slots <= '0;
            sub   <= '0;
        end else if (load_i) begin
            slots <= slots_i;
            sub   <= '0;
        end else if (slots != '0) begin
            if (sub == SUB_W'(SLOT_CLKS - 1)) begin
                sub   <= '0;
                slots <= slots - CAP'(1);
            end else begin
                sub <= sub + SUB_W'(1);
            end
        end
    end

    assign zero_o = (slots == '0);

    assert_idle_stays_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_o && !load_i) |=> zero_o);

    assert_count_monotone_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !zero_o) |=> (slots <= $past(slots)));

endmodule

// File: rtl/hdx_mii_tx.sv
// Module: hdx_mii_tx
// Transmit side of a half-duplex MAC on a 4-bit MII. Streams a frame
// from a rewindable nibble source and replaces the rest of the frame
// with a jam on collision. It backs off for a random number of slots,
// retries from nibble 0, and aborts after MAX_ATTEMPTS collisions.
// Assumes: the source presents the nibble at its current index
// combinationally and holds frame_pending_i until sent_ok_o or
// sent_abort_o.
module hdx_mii_tx
    import hdx_tx_pkg::*;
#(
    parameter int IFG_NIBBLES  = 24,
    parameter int SLOT_CLKS    = 128,
    parameter int MAX_ATTEMPTS = 16,
    parameter int BACKOFF_CAP  = 10,
    parameter int JAM_NIBBLES  = 8,
    parameter int LFSR_W       = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       half_duplex_i,
    input  logic       frame_pending_i,
    input  logic [3:0] src_nibble_i,
    input  logic       src_last_i,
    output logic       src_next_o,
    output logic       src_rewind_o,
    input  logic       crs_i,
    input  logic       col_i,
    output logic [3:0] txd_o,
    output logic       tx_en_o,
    output logic       sent_ok_o,
    output logic       sent_abort_o
);

    localparam int GAP_W = $clog2(IFG_NIBBLES + 1);
    localparam int ATT_W = $clog2(MAX_ATTEMPTS + 1);
    localparam int JAM_W = $clog2(JAM_NIBBLES + 1);

    tx_state_e              state;
    logic [GAP_W-1:0]       gap;
    logic [ATT_W-1:0]       coll_cnt;
    logic [ATT_W-1:0]       n_next;
    logic [JAM_W-1:0]       jam_cnt;
    logic [1:0]             sync_q;
    logic                   crs_s, col_s, crs_eff, col_eff;
    logic                   gap_ok, jam_end, final_coll;
    logic [BACKOFF_CAP-1:0] rnd, bo_mask, bo_slots;
    logic                   bo_load, bo_zero;

    // Retime carrier sense and collision into the transmit clock.
    hdx_sync2 #(.W(2)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({crs_i, col_i}),
        .q_o   (sync_q)
    );
    assign crs_s   = sync_q[1];
    assign col_s   = sync_q[0];
    assign crs_eff = half_duplex_i & crs_s;
    assign col_eff = half_duplex_i & col_s;

    // Inter-frame gap: quiet clocks since our last nibble or carrier.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap <= '0;
        end else if (tx_en_o || crs_eff) begin
            gap <= '0;
        end else if (!gap_ok) begin
            gap <= gap + GAP_W'(1);
        end
    end
    assign gap_ok = (gap == GAP_W'(IFG_NIBBLES));

    assign jam_end    = (state == ST_JAM) && (jam_cnt == JAM_W'(JAM_NIBBLES));
    assign final_coll = (coll_cnt == ATT_W'(MAX_ATTEMPTS - 1));
    assign n_next     = coll_cnt + ATT_W'(1);

    // Backoff window: the low min(n, cap) bits of the random value.
    hdx_lfsr #(.W(LFSR_W), .OUT_W(BACKOFF_CAP)) lfsr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .rnd_o (rnd)
    );
    for (genvar i = 0; i < BACKOFF_CAP; i++) begin : g_mask
        assign bo_mask[i] = (int'(n_next) > i);
    end
    assign bo_slots = rnd & bo_mask;
    assign bo_load  = jam_end && !final_coll;

    hdx_backoff #(.SLOT_CLKS(SLOT_CLKS), .CAP(BACKOFF_CAP)) backoff_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (bo_load),
        .slots_i (bo_slots),
        .zero_o  (bo_zero)
    );

    assign src_next_o   = (state == ST_TX) && !col_eff;
    assign src_rewind_o = jam_end;

    // Attempt sequencer: send, jam, back off, retry or give up.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            txd_o        <= '0;
            tx_en_o      <= 1'b0;
            coll_cnt     <= '0;
            jam_cnt      <= '0;
            sent_ok_o    <= 1'b0;
            sent_abort_o <= 1'b0;
        end else begin
            tx_en_o      <= 1'b0;
            txd_o        <= '0;
            sent_ok_o    <= 1'b0;
            sent_abort_o <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (frame_pending_i && gap_ok && !crs_eff) begin
                        state <= ST_TX;
                    end
                end
                ST_TX: begin
                    tx_en_o <= 1'b1;
                    if (col_eff) begin
                        txd_o   <= JAM_NIBBLE;
                        jam_cnt <= JAM_W'(1);
                        state   <= ST_JAM;
                    end else begin
                        txd_o <= src_nibble_i;
                        if (src_last_i) begin
                            state <= ST_DONE;
                        end
                    end
                end
                ST_DONE: begin
                    sent_ok_o <= 1'b1;
                    coll_cnt  <= '0;
                    state     <= ST_IDLE;
                end
                ST_JAM: begin
                    if (jam_end) begin
                        if (final_coll) begin
                            sent_abort_o <= 1'b1;
                            coll_cnt     <= '0;
                            state        <= ST_IDLE;
                        end else begin
                            coll_cnt <= n_next;
                            state    <= ST_BACKOFF;
                        end
                    end else begin
                        tx_en_o <= 1'b1;
                        txd_o   <= JAM_NIBBLE;
                        jam_cnt <= jam_cnt + JAM_W'(1);
                    end
                end
                ST_BACKOFF: begin
                    if (bo_zero) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_jam_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_JAM && tx_en_o) |-> (txd_o == JAM_NIBBLE));

    assert_jam_holds_txen_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_JAM && !jam_end) |=> tx_en_o);

    assert_rewind_ends_burst_R4: assert property (@(posedge clk) disable iff (!rst_n)
        src_rewind_o |=> !tx_en_o);

    assert_attempt_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        coll_cnt < ATT_W'(MAX_ATTEMPTS));

    assert_one_outcome_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(sent_ok_o && sent_abort_o));

    assert_fd_no_jam_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TX && !half_duplex_i) |=> (state != ST_JAM));

    assert_defer_on_crs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && half_duplex_i && crs_s) |=> (state != ST_TX));

endmodule

// File: tb/hdx_mii_tx_tb_top.sv
`timescale 1ns/1ps
module hdx_mii_tx_tb_top;

    localparam int IFG  = 24;
    localparam int SLOT = 2;
    localparam int CAP  = 10;
    localparam int JAMN = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic       hd = 1'b0, pending = 1'b0, crs = 1'b0, col = 1'b0;
    logic [3:0] src_nib, txd;
    logic       src_last, src_next, src_rewind, tx_en, sent_ok, sent_abort;
    logic       src_clr = 1'b1, inj_clr = 1'b1;
    int         flen = 12, idx = 0, quota = 0, pulses = 0, en_run = 0;
    int         checks = 0, errors = 0;

    function automatic logic [3:0] fnib(int i);
        logic [3:0] v;
        v = 4'(i * 7 + 3);
        if (v == 4'h5) v = 4'hC;
        return v;
    endfunction

    // Rewindable frame source model.
    assign src_nib  = (idx < flen) ? fnib(idx) : 4'h0;
    assign src_last = (idx == flen - 1);
    always @(posedge clk) begin
        if (src_clr || src_rewind) idx <= 0;
        else if (src_next)         idx <= idx + 1;
    end

    hdx_mii_tx #(.IFG_NIBBLES(IFG), .SLOT_CLKS(SLOT), .MAX_ATTEMPTS(16),
                 .BACKOFF_CAP(CAP), .JAM_NIBBLES(JAMN), .LFSR_W(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .half_duplex_i(hd), .frame_pending_i(pending),
        .src_nibble_i(src_nib), .src_last_i(src_last), .src_next_o(src_next),
        .src_rewind_o(src_rewind), .crs_i(crs), .col_i(col), .txd_o(txd),
        .tx_en_o(tx_en), .sent_ok_o(sent_ok), .sent_abort_o(sent_abort));

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Collision injector: one-clock pulse three clocks into a burst.
    always @(negedge clk) begin
        if (inj_clr) begin
            pulses = 0; en_run = 0; col = 1'b0;
        end else begin
            col = 1'b0;
            if (tx_en) en_run++; else en_run = 0;
            if (tx_en && en_run == 3 && pulses < quota) begin
                col = 1'b1;
                pulses++;
            end
        end
    end

    // Scoreboard: expected outcome per frame, popped by the monitor.
    typedef struct { int cols; bit abort; } exp_t;
    exp_t       sb[$];
    logic [3:0] burst[$];
    bit         prev_en = 0, last_col = 0, seen = 0, last_full = 0;
    int         low_cnt = 0, col_cnt = 0;

    function automatic bit prefix_ok(int n);
        if (n > flen) return 0;
        for (int i = 0; i < n; i++) if (burst[i] != fnib(i)) return 0;
        return 1;
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            if (tx_en) begin
                if (!prev_en) begin
                    if (seen) check(low_cnt >= IFG + 2, "R9", "idle gap", low_cnt, IFG + 2);
                    if (last_col) begin
                        int e, lim;
                        e   = (col_cnt < CAP) ? col_cnt : CAP;
                        lim = ((1 << e) - 1) * SLOT + 3;
                        if (lim < IFG + 2) lim = IFG + 2;
                        check(low_cnt <= lim, "R5", "backoff gap", low_cnt, lim);
                    end
                    seen = 1; low_cnt = 0;
                end
                burst.push_back(txd);
            end else begin
                if (prev_en) begin
                    int L;
                    L = burst.size();
                    if (L == flen && prefix_ok(L)) begin
                        last_full = 1; last_col = 0;
                    end else begin
                        bit jam_ok;
                        jam_ok = (L > JAMN);
                        for (int i = 0; i < JAMN && jam_ok; i++)
                            if (burst[L - 1 - i] != 4'h5) jam_ok = 0;
                        check(jam_ok, "R3", "burst ends in 8 jam nibbles, length", L, JAMN);
                        check(jam_ok && prefix_ok(L - JAMN), "R4", "burst starts at nibble 0, prefix len",
                              L - JAMN, L - JAMN);
                        col_cnt++; last_col = 1; last_full = 0;
                    end
                    burst.delete();
                end
                low_cnt++;
            end
            if (sent_ok || sent_abort) begin
                exp_t e;
                check(!tx_en && prev_en, "R2", "outcome on first low clock", tx_en, 0);
                if (sb.size() == 0) begin
                    check(0, "R2", "unexpected outcome", 1, 0);
                end else begin
                    e = sb.pop_front();
                    check(col_cnt == e.cols, e.abort ? "R6" : "R4", "collision bursts", col_cnt, e.cols);
                    check(sent_abort == e.abort, "R6", "abort flag", sent_abort, e.abort);
                    if (!e.abort) check(last_full, "R2", "final burst is whole frame", last_full, 1);
                end
                col_cnt = 0; last_col = 0;
            end
            prev_en = tx_en;
        end
    end

    task automatic run_frame(bit mode, int len, int q, int ecols, bit eabort);
        exp_t e;
        e.cols = ecols; e.abort = eabort;
        sb.push_back(e);
        @(negedge clk); hd = mode; flen = len; quota = q; inj_clr = 1; src_clr = 1;
        @(negedge clk); inj_clr = 0; src_clr = 0; pending = 1;
        do @(negedge clk); while (!(sent_ok || sent_abort));
        pending = 0;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: outputs idle in reset and just after release
        check(!tx_en && !sent_ok && !sent_abort, "R1", "outputs in reset", tx_en, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_en == 0 && txd == 0, "R1", "tx idle after reset", {txd, tx_en}, 0);
        check(!sent_ok && !sent_abort, "R1", "no outcome after reset", sent_ok | sent_abort, 0);
        check(!src_next && !src_rewind, "R1", "no source strobes", src_next | src_rewind, 0);
        src_clr = 0;
        repeat (3) @(negedge clk);

        // R2: plain full-duplex frame
        run_frame(0, 12, 0, 0, 0);

        // R7: full duplex with carrier and a collision pulse present
        crs = 1;
        run_frame(0, 12, 1, 0, 0);
        crs = 0;
        repeat (4) @(negedge clk);

        // R8: defer while carrier is up in half duplex
        begin
            exp_t e;
            int   seen_en, wait_cnt;
            e.cols = 0; e.abort = 0;
            sb.push_back(e);
            hd = 1; crs = 1; flen = 16; quota = 0; inj_clr = 0; src_clr = 1;
            @(negedge clk); src_clr = 0; pending = 1;
            seen_en = 0;
            repeat (40) begin @(negedge clk); if (tx_en) seen_en++; end
            check(seen_en == 0, "R8", "no burst under carrier", seen_en, 0);
            crs = 0; wait_cnt = 0;
            while (!tx_en && wait_cnt < 500) begin @(negedge clk); wait_cnt++; end
            check(wait_cnt >= IFG + 2, "R8", "gap after carrier drop", wait_cnt, IFG + 2);
            do @(negedge clk); while (!(sent_ok || sent_abort));
            pending = 0;
            repeat (5) @(negedge clk);
        end

        // R3 R4 R5: three collisions then success
        run_frame(1, 20, 3, 3, 0);
        // R6: every attempt collides, frame aborted
        run_frame(1, 12, 100, 16, 1);
        // R2: half duplex without collision after an abort
        run_frame(1, 8, 0, 0, 0);

        check(sb.size() == 0, "R2", "scoreboard drained", sb.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule